// File: doc/BRIEF.md
# Runtime-Polynomial LFSR Random Source

This block is a 16-bit linear-feedback shift register that feeds a stochastic decision stage with an 8-bit comparison value. Its feedback taps come from a polynomial mask register, so software or a neighbouring block can choose the sequence at run time. A short-period polynomial is used after reset, and a maximal-length one can be loaded whenever it is needed. Each enabled cycle the register shifts left by one place. The new bit 0 is the parity of the state bits selected by the mask.

The comparison value is a fixed byte window of the state. Because of that, successive values share seven bits and are strongly correlated. A decimation option raises the sample-valid strobe only on every sixteenth enabled shift. The consumer then sees values that do not overlap. A seed-load strobe writes a new state and a new mask together, and it restarts the decimation phase.

Top module: `lfsr_rand_src`

## Requirements
- R1: While `rst` is high at a clock edge (synchronous), the state becomes 16'h0001, the mask register becomes 16'h0030 and `sampleValid` becomes 0.
- R2: On a clock edge with `en`=1 and `seedLoad`=0, the state moves to `{state[14:0], fb}`, where `fb` is the XOR of all bits of `state & mask`.
- R3: On a clock edge with `en`=0 and `seedLoad`=0, the state and the mask are unchanged and `sampleValid` becomes 0. Cycles with `en` low do not count towards the decimation phase.
- R4: On a clock edge with `seedLoad`=1, the state takes `seedVal` and the mask takes `polyMask`, whatever `en` is. `sampleValid` becomes 0 and the decimation phase restarts at zero.
- R5: A `seedVal` of zero is replaced by 16'h0001 when it is loaded, so the all-zero lockup state is never seeded.
- R6: `cmpWindow` always equals `lfsrState[7:0]`.
- R7: With the reset mask 16'h0030 and the reset state, once 16 shifts have passed the state sequence repeats with a period of exactly 63 shifts.
- R8: With mask 16'hD008 loaded together with seed 16'h0001, the state first returns to 16'h0001 after exactly 65535 shifts.
- R9: With `decimEn`=0, `sampleValid` is 1 in the cycle after every enabled shift.
- R10: With `decimEn`=1, `sampleValid` is 1 only after the shift that completes each group of 16 enabled shifts. Groups are counted from the last reset or seed load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the register by one shift |
| polyMask | input | 16 | Feedback tap mask, captured on seed load |
| seedLoad | input | 1 | Load strobe for seed and mask, has priority over shifting |
| seedVal | input | 16 | Seed state written on load |
| decimEn | input | 1 | Raise the sample strobe only on every sixteenth shift |
| lfsrState | output | 16 | Current register state |
| cmpWindow | output | 8 | Comparison byte, low byte of the state |
| sampleValid | output | 1 | Comparison byte is a fresh sample |

## Verification
The hardest conditions to reach from the ports are the full 65535-state wrap of a maximal polynomial and the decimation phase in the middle of a group. The phase is hidden, and `en` gaps or seed loads land partway through a group. The stimulus loads the maximal mask and runs a full cycle of shifts while counting the first return to the seed. It then enables decimation under a pattern of enable gaps and places a seed load after a partial group. A behavioural model, stepped on every clock, predicts each strobe position.

// File: rtl/lfsr_rand_pkg.sv
package lfsr_rand_pkg;

  // Strobes issued by the control unit to the datapath each cycle.
  typedef struct packed {
    logic load;   // write seed and mask
    logic shift;  // advance the register one position
  } lfsr_strobe_t;

endpackage

// File: rtl/lfsr_rand_ctrl.sv
module lfsr_rand_ctrl
  import lfsr_rand_pkg::*;
#(
  parameter int DECIM = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         seedLoad,
  input  logic         decimEn,
  output lfsr_strobe_t strobe,
  output logic         sampleValid
);

  localparam int CNT_W = (DECIM > 1) ? $clog2(DECIM) : 1;
  localparam logic [CNT_W-1:0] LAST_PHASE = CNT_W'(DECIM - 1);

  logic [CNT_W-1:0] phaseCnt;
  logic             groupDone;
  logic             validNext;

  always_comb begin
    strobe.load  = seedLoad;
    strobe.shift = en && !seedLoad;
  end

  assign groupDone = (phaseCnt == LAST_PHASE);
  assign validNext = strobe.shift && (!decimEn || groupDone);

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseCnt    <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= validNext;
      if (strobe.load) begin
        phaseCnt <= '0;
      end else if (strobe.shift) begin
        phaseCnt <= groupDone ? '0 : phaseCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/lfsr_rand_dp.sv
module lfsr_rand_dp
  import lfsr_rand_pkg::*;
#(
  parameter int                 STATE_W    = 16,
  parameter int                 WIN_W      = 8,
  parameter int                 WIN_LSB    = 0,
  parameter logic [STATE_W-1:0] RESET_POLY = 16'h0030,
  parameter logic [STATE_W-1:0] RESET_SEED = 16'h0001
) (
  input  logic               clk,
  input  logic               rst,
  input  lfsr_strobe_t       strobe,
  input  logic [STATE_W-1:0] polyIn,
  input  logic [STATE_W-1:0] seedIn,
  output logic [STATE_W-1:0] stateOut,
  output logic [WIN_W-1:0]   windowOut
);

  localparam logic [STATE_W-1:0] NONZERO_FILL = STATE_W'(1);
  localparam logic [STATE_W-1:0] SAFE_RESET   =
    (RESET_SEED == '0) ? NONZERO_FILL : RESET_SEED;

  logic [STATE_W-1:0] stateQ;
  logic [STATE_W-1:0] polyQ;
  logic [STATE_W-1:0] tapChain;
  logic [STATE_W-1:0] seedSafe;
  logic               feedback;

  // Parity of the masked state, built as a ripple of XOR terms.
  assign tapChain[0] = stateQ[0] & polyQ[0];
  for (genvar i = 1; i < STATE_W; i++) begin : g_tap
    assign tapChain[i] = tapChain[i-1] ^ (stateQ[i] & polyQ[i]);
  end
  assign feedback = tapChain[STATE_W-1];

  assign seedSafe = (seedIn == '0) ? NONZERO_FILL : seedIn;

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= SAFE_RESET;
      polyQ  <= RESET_POLY;
    end else if (strobe.load) begin
      stateQ <= seedSafe;
      polyQ  <= polyIn;
    end else if (strobe.shift) begin
      stateQ <= {stateQ[STATE_W-2:0], feedback};
    end
  end

  assign stateOut  = stateQ;
  assign windowOut = stateQ[WIN_LSB +: WIN_W];

endmodule

// File: rtl/lfsr_rand_src.sv
module lfsr_rand_src
  import lfsr_rand_pkg::*;
#(
  parameter int                 STATE_W    = 16,
  parameter int                 WIN_W      = 8,
  parameter int                 WIN_LSB    = 0,
  parameter int                 DECIM      = 16,
  parameter logic [STATE_W-1:0] RESET_POLY = 16'h0030,
  parameter logic [STATE_W-1:0] RESET_SEED = 16'h0001
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [STATE_W-1:0] polyMask,
  input  logic               seedLoad,
  input  logic [STATE_W-1:0] seedVal,
  input  logic               decimEn,
  output logic [STATE_W-1:0] lfsrState,
  output logic [WIN_W-1:0]   cmpWindow,
  output logic               sampleValid
);

  lfsr_strobe_t strobe;

  lfsr_rand_ctrl #(
    .DECIM(DECIM)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .seedLoad   (seedLoad),
    .decimEn    (decimEn),
    .strobe     (strobe),
    .sampleValid(sampleValid)
  );

  lfsr_rand_dp #(
    .STATE_W   (STATE_W),
    .WIN_W     (WIN_W),
    .WIN_LSB   (WIN_LSB),
    .RESET_POLY(RESET_POLY),
    .RESET_SEED(RESET_SEED)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .polyIn   (polyMask),
    .seedIn   (seedVal),
    .stateOut (lfsrState),
    .windowOut(cmpWindow)
  );

endmodule

// File: rtl/lfsr_rand_chk.sv
module lfsr_rand_chk #(
  parameter int STATE_W = 16,
  parameter int WIN_W   = 8,
  parameter int DECIM   = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               en,
  input logic               seedLoad,
  input logic [STATE_W-1:0] seedVal,
  input logic               decimEn,
  input logic [STATE_W-1:0] lfsrState,
  input logic               sampleValid
);

  localparam int CNT_W = (DECIM > 1) ? $clog2(DECIM) : 1;
  localparam logic [STATE_W-1:0] ONE = STATE_W'(1);

  // Independent count of enabled shifts within the current group.
  logic [CNT_W-1:0] shiftCnt;
  always_ff @(posedge clk) begin
    if (rst || seedLoad) begin
      shiftCnt <= '0;
    end else if (en) begin
      shiftCnt <= (int'(shiftCnt) == DECIM - 1) ? '0 : shiftCnt + 1'b1;
    end
  end

  p_shift_r2: assert property (@(posedge clk) disable iff (rst)
    (en && !seedLoad) |=> lfsrState[STATE_W-1:1] == $past(lfsrState[STATE_W-2:0]));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!en && !seedLoad) |=> ($stable(lfsrState) && !sampleValid));

  p_load_r4: assert property (@(posedge clk) disable iff (rst)
    (seedLoad && seedVal != '0) |=> (lfsrState == $past(seedVal) && !sampleValid));

  p_zero_seed_r5: assert property (@(posedge clk) disable iff (rst)
    (seedLoad && seedVal == '0) |=> (lfsrState == ONE));

  p_every_shift_r9: assert property (@(posedge clk) disable iff (rst)
    (en && !seedLoad && !decimEn) |=> sampleValid);

  p_decim_group_r10: assert property (@(posedge clk) disable iff (rst)
    (en && !seedLoad && decimEn) |=> (sampleValid == (shiftCnt == '0)));

endmodule

bind lfsr_rand_src lfsr_rand_chk #(
  .STATE_W(STATE_W),
  .WIN_W  (WIN_W),
  .DECIM  (DECIM)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .seedLoad   (seedLoad),
  .seedVal    (seedVal),
  .decimEn    (decimEn),
  .lfsrState  (lfsrState),
  .sampleValid(sampleValid)
);

// File: tb/lfsr_rand_src_bench.sv
module lfsr_rand_src_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [15:0] polyMask = 16'h0000;
  logic        seedLoad = 1'b0;
  logic [15:0] seedVal = 16'h0000;
  logic        decimEn = 1'b0;
  logic [15:0] lfsrState;
  logic [7:0]  cmpWindow;
  logic        sampleValid;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string curReq = "R1";

  // Behavioural reference state.
  int mState = 1;
  int mMask = 'h30;
  int mPhase = 0;
  bit mValid = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lfsr_rand_src u_lfsr_rand_src (
    .clk(clk), .rst(rst), .en(en), .polyMask(polyMask), .seedLoad(seedLoad),
    .seedVal(seedVal), .decimEn(decimEn), .lfsrState(lfsrState),
    .cmpWindow(cmpWindow), .sampleValid(sampleValid)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  function automatic int parity(int v);
    int p = 0;
    for (int b = 0; b < 16; b++) p ^= (v >> b) & 1;
    return p;
  endfunction

  task automatic modelStep();
    if (rst) begin
      mState = 1; mMask = 'h30; mPhase = 0; mValid = 0;
    end else if (seedLoad) begin
      mState = (seedVal == 0) ? 1 : int'(seedVal);
      mMask = int'(polyMask); mPhase = 0; mValid = 0;
    end else if (en) begin
      mState = ((mState << 1) & 'hFFFF) | parity(mState & mMask);
      mValid = !decimEn || (mPhase == 15);
      mPhase = (mPhase + 1) % 16;
    end else begin
      mValid = 0;
    end
  endtask

  // One clock: update the model at the edge, compare shortly after.
  task automatic tick();
    @(posedge clk);
    modelStep();
    #1;
    chk(curReq, int'(lfsrState), mState);
    chk("R6", int'(cmpWindow), mState & 'hFF);
    chk((decimEn ? "R10" : "R9"), int'(sampleValid), int'(mValid));
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int ref16;
    int period;
    int count;
    // R1: reset state
    curReq = "R1";
    tick(); tick();
    chk("R1", int'(lfsrState), 'h0001);
    chk("R1", int'(sampleValid), 0);
    rst = 1'b0;

    // R2 / R9: shifting with the reset polynomial
    curReq = "R2";
    en = 1'b1;
    for (int i = 0; i < 16; i++) tick();
    // R7: measure period after 16 shifts
    ref16 = int'(lfsrState);
    period = 0;
    for (int i = 0; i < 200; i++) begin
      tick();
      if (period == 0 && int'(lfsrState) == ref16) period = i + 1;
    end
    chk("R7", period, 63);

    // R3: enable gaps hold state
    curReq = "R3";
    for (int i = 0; i < 40; i++) begin
      en = (i % 3) != 0;
      tick();
    end
    en = 1'b0;
    ref16 = int'(lfsrState);
    tick(); tick();
    chk("R3", int'(lfsrState), ref16);

    // R4: load with enable high has priority; mask takes effect
    curReq = "R4";
    en = 1'b1; seedLoad = 1'b1; seedVal = 16'hACE1; polyMask = 16'hD008;
    tick();
    chk("R4", int'(lfsrState), 'hACE1);
    chk("R4", int'(sampleValid), 0);
    seedLoad = 1'b0;
    curReq = "R2";
    for (int i = 0; i < 30; i++) tick();

    // R5: zero seed replaced by one
    curReq = "R5";
    seedLoad = 1'b1; seedVal = 16'h0000;
    tick();
    chk("R5", int'(lfsrState), 'h0001);
    seedLoad = 1'b0;

    // R10: decimation with gaps and a load partway through a group
    curReq = "R10";
    decimEn = 1'b1;
    for (int i = 0; i < 90; i++) begin
      en = (i % 5) != 2;
      tick();
    end
    en = 1'b1;
    for (int i = 0; i < 7; i++) tick();
    seedLoad = 1'b1; seedVal = 16'h1234; polyMask = 16'hD008;
    tick();
    seedLoad = 1'b0;
    count = 0;
    for (int i = 0; i < 48; i++) begin
      tick();
      if (sampleValid) count++;
      if (i == 14) chk("R10", int'(sampleValid), 0);
      if (i == 15) chk("R10", int'(sampleValid), 1);
    end
    chk("R10", count, 3);
    decimEn = 1'b0;

    // R8: full maximal-length period
    curReq = "R8";
    seedLoad = 1'b1; seedVal = 16'h0001; polyMask = 16'hD008;
    tick();
    seedLoad = 1'b0;
    period = 0;
    for (int i = 0; i < 65600; i++) begin
      tick();
      if (period == 0 && lfsrState == 16'h0001) period = i + 1;
    end
    chk("R8", period, 65535);

    // R1 again: reset mid-run restores defaults
    curReq = "R1";
    rst = 1'b1;
    tick();
    chk("R1", int'(lfsrState), 'h0001);
    rst = 1'b0;
    curReq = "R2";
    for (int i = 0; i < 20; i++) tick();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule